// File: doc/BRIEF.md
# Bracket-Language Stack Processor Core

This block is an 8-bit processor that runs a tape language with eight symbols directly. It keeps three registers: a data pointer that selects the current cell, a program counter, and a loop-stack pointer. Every instruction fetch, cell access and stack access goes through one memory port with synchronous reads. The port has an address, a read strobe, a write strobe and separate read and write data buses. Read data arrives one cycle after the read strobe. ROM occupies addresses 0x00 to 0x3F and RAM occupies 0x40 to 0xFF.

A loop opening checks the current cell. If the cell is nonzero, the opening's own address is stored on a stack in RAM that grows downward. If the cell is zero, a separate scanner module walks forward byte by byte to the matching closing symbol, counting nesting as it goes. A loop closing with a nonzero cell reloads the program counter from the stack top and leaves the stack as it is. A loop closing with a zero cell pops the stack.

Byte input uses a ready/valid handshake. Byte output is a one-cycle valid pulse. After a halt, the core stays halted and touches no memory until it is reset.

Top module: `bfk_core`

## Requirements
- R1: During reset and on the cycle it is released, `halted` is 0 and the core is fetching from address 0x00. The data pointer starts at 0x40. The stack pointer starts at 0x00, so the first push lands at 0xFF.
- R2: Opcodes are 0x00 halt, 0x01 cell+1, 0x02 cell-1, 0x03 pointer+1, 0x04 pointer-1, 0x05 input, 0x06 output, 0x07 loop open, 0x08 loop close and 0x09 no-op. Every other byte (for example 0x0A or 0xFF) behaves as a no-op.
- R3: Opcodes 0x01 and 0x02 read the cell at the pointer and write back the value plus or minus one, modulo 256.
- R4: Opcodes 0x03 and 0x04 move the pointer by +1 or -1, and later cell accesses use the new address.
- R5: Opcode 0x05 holds `io_in_ready` high until `io_in_valid` is seen, writes `io_in_data` into the cell at the pointer, and then drops `io_in_ready`.
- R6: Opcode 0x06 raises `io_out_valid` for exactly one cycle, with `io_out_data` equal to the cell at the pointer.
- R7: A loop open on a nonzero cell decrements the stack pointer and then writes the opening's own address at the new stack pointer.
- R8: A loop open on a zero cell resumes after the matching loop close, honoring nesting. Nothing in between is executed, and the stack pointer ends unchanged.
- R9: A loop close on a nonzero cell reloads the program counter from memory at the stack pointer, so execution continues just after the loop open. The stack pointer is left unchanged.
- R10: A loop close on a zero cell increments the stack pointer (pop).
- R11: After opcode 0x00, `halted` stays 1 and neither memory strobe is raised until reset.
- R12: Each completed instruction other than a taken loop jump advances the program counter by exactly one.
- R13: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 8 | Memory address |
| mem_rd | output | 1 | Read strobe; data is valid on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| io_in_data | input | 8 | Input byte |
| io_in_valid | input | 1 | Input byte is present |
| io_in_ready | output | 1 | Core is waiting for an input byte |
| io_out_data | output | 8 | Output byte |
| io_out_valid | output | 1 | One-cycle output strobe |
| halted | output | 1 | Core has executed a halt |

## Verification
Four properties are checked every cycle:
- the strobes stay exclusive;
- halt is sticky and keeps the memory port quiet;
- input and output strobes last a single cycle;
- the advance step adds one to the program counter, and the stack pointer is preserved or popped correctly at each loop close.

Where a push lands, which instructions the skip scanner jumps over, the wrap of cell values, and the pointer addressing can only be shown by the bench programs. Each program's output stream and final memory image are compared with values derived by hand.

// File: rtl/bfk_pkg.sv
package bfk_pkg;

    localparam logic [7:0] OP_HALT  = 8'h00;
    localparam logic [7:0] OP_INC   = 8'h01;
    localparam logic [7:0] OP_DEC   = 8'h02;
    localparam logic [7:0] OP_FWD   = 8'h03;
    localparam logic [7:0] OP_BACK  = 8'h04;
    localparam logic [7:0] OP_IN    = 8'h05;
    localparam logic [7:0] OP_OUT   = 8'h06;
    localparam logic [7:0] OP_OPEN  = 8'h07;
    localparam logic [7:0] OP_CLOSE = 8'h08;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_CELL_RD,
        ST_CELL_WR,
        ST_IN_WAIT,
        ST_OUT_EMIT,
        ST_LB_SP,
        ST_LB_RD,
        ST_LB_CHK,
        ST_LB_SCAN,
        ST_LB_SPUP,
        ST_RB_RD,
        ST_RB_CHK,
        ST_RB_LOAD,
        ST_ADVANCE,
        ST_HALT
    } core_st_e;

endpackage

// File: rtl/bfk_step_alu.sv
module bfk_step_alu #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] opnd,
    input  logic         sub,
    output logic [W-1:0] res,
    input  logic [W-1:0] probe,
    output logic         probe_zero
);
    // Plus or minus one only; wraps modulo 2^W.
    always_comb begin
        if (sub) res = opnd - W'(1);
        else     res = opnd + W'(1);
    end

    assign probe_zero = (probe == '0);
endmodule

// File: rtl/bfk_skip_scan.sv
module bfk_skip_scan #(
    parameter int unsigned DW      = 8,
    parameter int unsigned DEPTH_W = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] origin,
    input  logic [DW-1:0] rdata,
    output logic          busy,
    output logic          rd_en,
    output logic [DW-1:0] rd_addr,
    output logic          done,
    output logic [DW-1:0] match_addr
);
    import bfk_pkg::*;

    typedef enum logic [1:0] {SC_IDLE, SC_ISSUE, SC_LOOK} scan_st_e;

    typedef struct packed {
        scan_st_e           st;
        logic [DW-1:0]      cursor;
        logic [DEPTH_W-1:0] depth;
    } scan_regs_t;

    scan_regs_t r_q, r_d;

    always_comb begin
        r_d        = r_q;
        rd_en      = 1'b0;
        rd_addr    = r_q.cursor;
        done       = 1'b0;
        match_addr = r_q.cursor;
        case (r_q.st)
            SC_IDLE: begin
                if (start) begin
                    r_d.cursor = origin + DW'(1);
                    r_d.depth  = DEPTH_W'(1);
                    r_d.st     = SC_ISSUE;
                end
            end
            SC_ISSUE: begin
                rd_en  = 1'b1;
                r_d.st = SC_LOOK;
            end
            SC_LOOK: begin
                if (rdata == DW'(OP_CLOSE) && r_q.depth == DEPTH_W'(1)) begin
                    done   = 1'b1;
                    r_d.st = SC_IDLE;
                end else begin
                    if (rdata == DW'(OP_CLOSE)) r_d.depth = r_q.depth - DEPTH_W'(1);
                    if (rdata == DW'(OP_OPEN))  r_d.depth = r_q.depth + DEPTH_W'(1);
                    r_d.cursor = r_q.cursor + DW'(1);
                    r_d.st     = SC_ISSUE;
                end
            end
            default: r_d.st = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= SC_IDLE;
            r_q.cursor <= '0;
            r_q.depth  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st != SC_IDLE);

    // R8: a scan is only launched from idle, and ends in idle
    a_r8_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/bfk_core.sv
module bfk_core #(
    parameter int unsigned DW        = 8,
    parameter int unsigned ROM_WORDS = 64,
    parameter int unsigned SCAN_DW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] io_in_data,
    input  logic          io_in_valid,
    output logic          io_in_ready,
    output logic [DW-1:0] io_out_data,
    output logic          io_out_valid,
    output logic          halted
);
    import bfk_pkg::*;

    localparam logic [DW-1:0] PTR_RESET = DW'(ROM_WORDS);
    localparam logic [DW-1:0] SP_RESET  = '0;   // one above top of RAM, wrapped
    localparam logic [DW-1:0] PC_RESET  = '0;

    typedef struct packed {
        core_st_e      st;
        logic [DW-1:0] pc;
        logic [DW-1:0] ptr;
        logic [DW-1:0] sp;
        logic [DW-1:0] ir;
    } core_regs_t;

    core_regs_t r_q, r_d;

    logic [DW-1:0] alu_opnd, alu_res;
    logic          alu_sub, cell_zero;

    logic          scan_start, scan_busy, scan_rd, scan_done;
    logic [DW-1:0] scan_addr, scan_match;

    bfk_step_alu #(.W(DW)) u_alu (
        .opnd       (alu_opnd),
        .sub        (alu_sub),
        .res        (alu_res),
        .probe      (mem_rdata),
        .probe_zero (cell_zero)
    );

    bfk_skip_scan #(.DW(DW), .DEPTH_W(SCAN_DW)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (scan_start),
        .origin     (r_q.pc),
        .rdata      (mem_rdata),
        .busy       (scan_busy),
        .rd_en      (scan_rd),
        .rd_addr    (scan_addr),
        .done       (scan_done),
        .match_addr (scan_match)
    );

    always_comb begin
        r_d          = r_q;
        mem_addr     = r_q.pc;
        mem_rd       = 1'b0;
        mem_wr       = 1'b0;
        mem_wdata    = '0;
        io_in_ready  = 1'b0;
        io_out_valid = 1'b0;
        io_out_data  = '0;
        alu_opnd     = r_q.pc;
        alu_sub      = 1'b0;
        scan_start   = 1'b0;
        case (r_q.st)
            ST_FETCH: begin
                mem_rd   = 1'b1;
                r_d.st   = ST_DECODE;
            end
            ST_DECODE: begin
                r_d.ir = mem_rdata;
                case (mem_rdata)
                    DW'(OP_HALT):  r_d.st = ST_HALT;
                    DW'(OP_INC),
                    DW'(OP_DEC),
                    DW'(OP_OUT):   r_d.st = ST_CELL_RD;
                    DW'(OP_FWD): begin
                        alu_opnd = r_q.ptr;
                        r_d.ptr  = alu_res;
                        r_d.st   = ST_ADVANCE;
                    end
                    DW'(OP_BACK): begin
                        alu_opnd = r_q.ptr;
                        alu_sub  = 1'b1;
                        r_d.ptr  = alu_res;
                        r_d.st   = ST_ADVANCE;
                    end
                    DW'(OP_IN):    r_d.st = ST_IN_WAIT;
                    DW'(OP_OPEN):  r_d.st = ST_LB_SP;
                    DW'(OP_CLOSE): r_d.st = ST_RB_RD;
                    default:       r_d.st = ST_ADVANCE;
                endcase
            end
            ST_CELL_RD: begin
                mem_addr = r_q.ptr;
                mem_rd   = 1'b1;
                r_d.st   = (r_q.ir == DW'(OP_OUT)) ? ST_OUT_EMIT : ST_CELL_WR;
            end
            ST_CELL_WR: begin
                alu_opnd  = mem_rdata;
                alu_sub   = (r_q.ir == DW'(OP_DEC));
                mem_addr  = r_q.ptr;
                mem_wr    = 1'b1;
                mem_wdata = alu_res;
                r_d.st    = ST_ADVANCE;
            end
            ST_OUT_EMIT: begin
                io_out_valid = 1'b1;
                io_out_data  = mem_rdata;
                r_d.st       = ST_ADVANCE;
            end
            ST_IN_WAIT: begin
                io_in_ready = 1'b1;
                if (io_in_valid) begin
                    mem_addr  = r_q.ptr;
                    mem_wr    = 1'b1;
                    mem_wdata = io_in_data;
                    r_d.st    = ST_ADVANCE;
                end
            end
            ST_LB_SP: begin
                alu_opnd = r_q.sp;
                alu_sub  = 1'b1;
                r_d.sp   = alu_res;
                r_d.st   = ST_LB_RD;
            end
            ST_LB_RD: begin
                mem_addr = r_q.ptr;
                mem_rd   = 1'b1;
                r_d.st   = ST_LB_CHK;
            end
            ST_LB_CHK: begin
                if (!cell_zero) begin
                    mem_addr  = r_q.sp;
                    mem_wr    = 1'b1;
                    mem_wdata = r_q.pc;
                    r_d.st    = ST_ADVANCE;
                end else begin
                    scan_start = 1'b1;
                    r_d.st     = ST_LB_SCAN;
                end
            end
            ST_LB_SCAN: begin
                mem_addr = scan_addr;
                mem_rd   = scan_rd;
                if (scan_done) begin
                    r_d.pc = scan_match;
                    r_d.st = ST_LB_SPUP;
                end
            end
            ST_LB_SPUP: begin
                alu_opnd = r_q.sp;
                r_d.sp   = alu_res;
                r_d.st   = ST_ADVANCE;
            end
            ST_RB_RD: begin
                mem_addr = r_q.ptr;
                mem_rd   = 1'b1;
                r_d.st   = ST_RB_CHK;
            end
            ST_RB_CHK: begin
                if (cell_zero) begin
                    alu_opnd = r_q.sp;
                    r_d.sp   = alu_res;
                    r_d.st   = ST_ADVANCE;
                end else begin
                    mem_addr = r_q.sp;
                    mem_rd   = 1'b1;
                    r_d.st   = ST_RB_LOAD;
                end
            end
            ST_RB_LOAD: begin
                r_d.pc = mem_rdata;
                r_d.st = ST_ADVANCE;
            end
            ST_ADVANCE: begin
                alu_opnd = r_q.pc;
                r_d.pc   = alu_res;
                r_d.st   = ST_FETCH;
            end
            ST_HALT: r_d.st = ST_HALT;
            default: r_d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_FETCH;
            r_q.pc  <= PC_RESET;
            r_q.ptr <= PTR_RESET;
            r_q.sp  <= SP_RESET;
            r_q.ir  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign halted = (r_q.st == ST_HALT);

    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !(mem_rd || mem_wr));
    a_r13_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    a_r6_out_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        io_out_valid |=> !io_out_valid);
    a_r5_in_accept_once: assert property (@(posedge clk) disable iff (!rst_n)
        (io_in_ready && io_in_valid) |=> !io_in_ready);
    a_r12_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ADVANCE) |=> (r_q.pc == DW'($past(r_q.pc) + 1)));
    a_r9_keep_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RB_LOAD) |-> (r_q.sp == $past(r_q.sp)));
    a_r10_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RB_CHK && mem_rdata == '0) |=> (r_q.sp == DW'($past(r_q.sp) + 1)));
    a_r8_scan_owns_port: assert property (@(posedge clk) disable iff (!rst_n)
        scan_busy |-> !mem_wr);
endmodule

// File: tb/bfk_core_tb.sv
module bfk_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, io_in_data, io_out_data;
    logic       mem_rd, mem_wr, io_in_valid, io_in_ready, io_out_valid, halted;

    logic [7:0] mem [0:255];
    logic       clr = 1'b0, ld_en = 1'b0;
    logic [7:0] ld_addr = 8'h00, ld_data = 8'h00;

    int n_checks = 0, n_fail = 0;
    logic [7:0] out_buf [0:31];
    int out_n, both_cnt, ready_cnt, in_idx, wait_cnt;
    logic [7:0] in_vals [0:1];
    bit finished = 0;

    always #4 clk = ~clk;

    bfk_core u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .io_in_data(io_in_data), .io_in_valid(io_in_valid), .io_in_ready(io_in_ready),
        .io_out_data(io_out_data), .io_out_valid(io_out_valid), .halted(halted)
    );

    // memory model: synchronous read, one cycle latency
    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
        end else if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end else begin
            if (mem_wr) mem[mem_addr] <= mem_wdata;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // output capture and port monitors
    always @(negedge clk) begin
        if (!rst_n) begin
            out_n = 0; both_cnt = 0; ready_cnt = 0;
        end else begin
            if (io_out_valid && out_n < 32) begin
                out_buf[out_n] = io_out_data;
                out_n++;
            end
            if (mem_rd && mem_wr) both_cnt++;
            if (io_in_ready) ready_cnt++;
        end
    end

    // input feeder: offers a byte on the 4th waiting cycle, for one cycle
    always @(negedge clk) begin
        if (!rst_n) begin
            io_in_valid = 1'b0; io_in_data = 8'h00; in_idx = 0; wait_cnt = 0;
        end else if (io_in_valid) begin
            io_in_valid = 1'b0; in_idx++; wait_cnt = 0;
        end else if (io_in_ready) begin
            wait_cnt++;
            if (wait_cnt == 4) begin
                io_in_data  = in_vals[in_idx % 2];
                io_in_valid = 1'b1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [7:0] d);
        ld_addr = 8'(a); ld_data = d; ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic wipe();
        rst_n = 1'b0;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic run(input string req);
        int t;
        @(negedge clk);
        rst_n = 1'b1;
        t = 0;
        while (!halted && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk({req, " reached halt"}, int'(halted), 1);
    endtask

    task automatic t_reset();
        wipe();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 halted low after reset", int'(halted), 0);
        chk("R1 first fetch strobe", int'(mem_rd), 1);
        chk("R1 first fetch address", int'(mem_addr), 8'h00);
        @(negedge clk);
        @(negedge clk);
        chk("R11 halt on opcode 00", int'(halted), 1);
    endtask

    task automatic t_arith();
        logic [7:0] p [0:12] = '{8'h01,8'h01,8'h01,8'h06,8'h02,8'h06,8'h02,8'h02,
                                 8'h02,8'h06,8'h01,8'h06,8'h00};
        wipe();
        for (int i = 0; i < 13; i++) put(i, p[i]);
        run("R3");
        chk("R3 output count", out_n, 4);
        chk("R3 inc to 3", int'(out_buf[0]), 3);
        chk("R3 dec to 2", int'(out_buf[1]), 2);
        chk("R3 dec wraps to FF", int'(out_buf[2]), 8'hFF);
        chk("R3 inc wraps to 00", int'(out_buf[3]), 0);
        chk("R1 pointer starts at 40", int'(mem[8'h40]), 0);
        chk("R13 strobes exclusive", both_cnt, 0);
    endtask

    task automatic t_pointer();
        logic [7:0] p [0:10] = '{8'h03,8'h01,8'h01,8'h03,8'h01,8'h06,8'h04,8'h06,
                                 8'h04,8'h06,8'h00};
        wipe();
        for (int i = 0; i < 11; i++) put(i, p[i]);
        run("R4");
        chk("R4 output count", out_n, 3);
        chk("R4 cell 42", int'(out_buf[0]), 1);
        chk("R4 cell 41 after back", int'(out_buf[1]), 2);
        chk("R4 cell 40 untouched", int'(out_buf[2]), 0);
        chk("R4 memory 41", int'(mem[8'h41]), 2);
        chk("R4 memory 42", int'(mem[8'h42]), 1);
    endtask

    task automatic t_input();
        logic [7:0] p [0:5] = '{8'h05,8'h06,8'h03,8'h05,8'h06,8'h00};
        wipe();
        in_vals[0] = 8'h5A; in_vals[1] = 8'hC3;
        for (int i = 0; i < 6; i++) put(i, p[i]);
        run("R5");
        chk("R5 ready cycles for two bytes", ready_cnt, 8);
        chk("R5 byte 0 stored", int'(mem[8'h40]), 8'h5A);
        chk("R5 byte 1 stored", int'(mem[8'h41]), 8'hC3);
        chk("R6 output count", out_n, 2);
        chk("R6 echo 0", int'(out_buf[0]), 8'h5A);
        chk("R6 echo 1", int'(out_buf[1]), 8'hC3);
    endtask

    task automatic t_loop();
        logic [7:0] p [0:11] = '{8'h01,8'h01,8'h01,8'h07,8'h06,8'h02,8'h08,
                                 8'h01,8'h07,8'h02,8'h08,8'h00};
        wipe();
        for (int i = 0; i < 12; i++) put(i, p[i]);
        run("R9");
        chk("R9 iteration count", out_n, 3);
        chk("R9 iter 0", int'(out_buf[0]), 3);
        chk("R9 iter 1", int'(out_buf[1]), 2);
        chk("R9 iter 2", int'(out_buf[2]), 1);
        chk("R7 R10 second push lands at FF after pop", int'(mem[8'hFF]), 8);
        chk("R10 nothing pushed at FE", int'(mem[8'hFE]), 0);
    endtask

    task automatic t_skip();
        logic [7:0] p [0:13] = '{8'h07,8'h01,8'h07,8'h01,8'h08,8'h06,8'h08,
                                 8'h03,8'h01,8'h06,8'h07,8'h02,8'h08,8'h00};
        wipe();
        for (int i = 0; i < 14; i++) put(i, p[i]);
        run("R8");
        chk("R8 only post-loop output", out_n, 1);
        chk("R8 post-loop value", int'(out_buf[0]), 1);
        chk("R8 skipped body left cell 40", int'(mem[8'h40]), 0);
        chk("R8 SP unchanged, push at FF", int'(mem[8'hFF]), 8'h0A);
        chk("R8 nothing at FE", int'(mem[8'hFE]), 0);
    endtask

    task automatic t_unknown();
        logic [7:0] p [0:6] = '{8'h01,8'h0A,8'hFF,8'h09,8'h01,8'h06,8'h00};
        wipe();
        for (int i = 0; i < 7; i++) put(i, p[i]);
        run("R2");
        chk("R2 unknown opcodes act as no-op", out_n, 1);
        chk("R2 R12 value after no-ops", int'(out_buf[0]), 2);
    endtask

    task automatic t_halt();
        int acc;
        logic [7:0] p [0:2] = '{8'h01,8'h00,8'h06};
        wipe();
        for (int i = 0; i < 3; i++) put(i, p[i]);
        run("R11");
        acc = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (mem_rd || mem_wr) acc++;
        end
        chk("R11 no memory access after halt", acc, 0);
        chk("R11 halted held", int'(halted), 1);
        chk("R11 no output after halt", out_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 reset clears halted", int'(halted), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_arith();
        t_pointer();
        t_input();
        t_loop();
        t_skip();
        t_unknown();
        t_halt();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule